// File: doc/BRIEF.md
# SD Host Transfer Mode Sequencer

This block sits in an SD host controller next to the DAT-line data path. Host software programs a transfer-mode control word and a block count over a small 16-bit byte-enabled register bus. The block reports what kind of transfer those settings describe and which way the data flows. A write to the upper byte of the command register launches the transfer. From then on the block counts finished blocks, raises a DMA start pulse when DMA may be used, and signals completion. It also asks for the stop command (CMD12) on its own after the final counted block.

The transfer kind depends on the multi-block flag, the count-enable flag and the current count. With multi-block off, every transfer is one block. With multi-block on and counting off, the transfer is open-ended and only an external abort ends it. With both on, the count sets the length, and a zero count means there is nothing to move. While a transfer runs, the control word and the count are locked against host writes, so only the block-done strobes change the count.

Register offsets (halfword-aligned byte addresses) are: control word at 0x0C (low byte), block count at 0x06 (16 bits), command at 0x0E (the upper byte, 0x0F, is the launch trigger).

Top module: `sd_xfer_mode_seq`

## Requirements
- R1: After reset the control word and block count read 0, and xfer_active, dma_start, stop_req and xfer_done are 0.
- R2: Control word bits (read at 0x0C, low byte): bit 5 multi-block, bit 4 direction, bit 2 auto-stop enable, bit 1 count enable, bit 0 DMA enable. Bits 3, 6 and 7 always read 0, whatever is written to them.
- R3: xfer_dir follows the direction bit: 0 = host to card (write), 1 = card to host (read).
- R4: xfer_type encoding: 0 single (multi-block off), 1 infinite (multi-block on, count enable off), 2 counted (both on, count nonzero), 3 stopped (both on, count zero).
- R5: A write with bus_be[1] set to address 0x0E while idle, with a type other than stopped, sets xfer_active in the next cycle. dma_start pulses for that one cycle only when the DMA enable bit and cap_dma are both 1.
- R6: During a counted transfer, each block_done lowers the block count (read at 0x06) by one.
- R7: The block_done that brings the count from 1 to 0 produces a one-cycle xfer_done in the next cycle and clears xfer_active.
- R8: stop_req pulses together with xfer_done at the end of a counted transfer only when auto-stop is enabled. A single-block end never raises it.
- R9: In an infinite transfer, block_done changes neither the count nor xfer_active, and raises no xfer_done.
- R10: abort clears xfer_active in the next cycle with no xfer_done or stop_req, and it takes priority over a block_done in the same cycle, which then does not decrement the count.
- R11: While xfer_active is 1, writes to the control word, the block count and the command trigger are ignored.
- R12: In a single-block transfer, the first block_done ends the transfer with xfer_done, leaves the count unchanged and raises no stop_req.
- R13: A command trigger while the type is stopped starts nothing: xfer_active and dma_start stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Halfword-aligned byte address |
| bus_be | input | 2 | Byte enables for bus_wdata |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for control word and block count |
| block_done | input | 1 | One-cycle strobe per finished block |
| abort | input | 1 | Ends the current transfer immediately |
| cap_dma | input | 1 | DMA support capability |
| xfer_type | output | 2 | Transfer classification |
| xfer_dir | output | 1 | Data direction |
| xfer_active | output | 1 | Transfer in progress |
| dma_start | output | 1 | One-cycle DMA launch pulse |
| stop_req | output | 1 | One-cycle auto-stop command request |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench targets the last block of a counted transfer. An off-by-one counter would end one block early or late, or would leave the pulses high for more than a cycle. It sends block strobes through an infinite transfer, where a design that consulted the count would stop on its own. It also gives abort and block_done in the same cycle, which catches a design that decrements or signals completion on the way out. Other checks cover writes made while a transfer is active, a trigger with a zero count, and DMA enabled while the capability input is low. Each of these cases exposes a missing gate as a spurious start or a changed register.

// File: rtl/sd_xfer_mode_seq.sv
module sd_xfer_mode_seq #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CNT_OFS  = 8'h06,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              block_done,
  input  logic              abort,
  input  logic              cap_dma,
  output logic [1:0]        xfer_type,
  output logic              xfer_dir,
  output logic              xfer_active,
  output logic              dma_start,
  output logic              stop_req,
  output logic              xfer_done
);
  localparam logic [1:0] T_SINGLE = 2'd0;
  localparam logic [1:0] T_INF    = 2'd1;
  localparam logic [1:0] T_MULTI  = 2'd2;
  localparam logic [1:0] T_STOP   = 2'd3;
  localparam logic [7:0] MODE_MASK = 8'h37;

  logic [7:0]  mode_q;
  logic [15:0] cnt_q;
  logic        active_q, dma_q, stop_q, done_q;

  wire multi    = mode_q[5];
  wire auto_en  = mode_q[2];
  wire cnt_en   = mode_q[1];
  wire dma_en   = mode_q[0];

  assign xfer_type = !multi ? T_SINGLE :
                     !cnt_en ? T_INF :
                     (cnt_q != 16'd0) ? T_MULTI : T_STOP;
  assign xfer_dir    = mode_q[4];
  assign xfer_active = active_q;
  assign dma_start   = dma_q;
  assign stop_req    = stop_q;
  assign xfer_done   = done_q;

  assign bus_rdata = (bus_addr == MODE_OFS) ? {8'h00, mode_q} :
                     (bus_addr == CNT_OFS)  ? cnt_q : 16'h0000;

  wire wr_ok   = bus_we && !active_q;
  wire mode_wr = wr_ok && bus_addr == MODE_OFS && bus_be[0];
  wire cnt_wr  = wr_ok && bus_addr == CNT_OFS && (|bus_be);
  wire go      = wr_ok && bus_addr == CMD_OFS && bus_be[1] && xfer_type != T_STOP;

  wire blk      = active_q && block_done && !abort;
  wire counting = blk && xfer_type == T_MULTI;
  wire last     = blk && (xfer_type == T_SINGLE || (xfer_type == T_MULTI && cnt_q == 16'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 8'h00;
      cnt_q    <= 16'h0000;
      active_q <= 1'b0;
      dma_q    <= 1'b0;
      stop_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata[7:0] & MODE_MASK;
      if (cnt_wr) begin
        if (bus_be[0]) cnt_q[7:0]  <= bus_wdata[7:0];
        if (bus_be[1]) cnt_q[15:8] <= bus_wdata[15:8];
      end else if (counting) begin
        cnt_q <= cnt_q - 16'd1;
      end
      if (abort)     active_q <= 1'b0;
      else if (go)   active_q <= 1'b1;
      else if (last) active_q <= 1'b0;
      dma_q  <= go && dma_en && cap_dma;
      done_q <= last;
      stop_q <= last && auto_en && xfer_type == T_MULTI;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7
  AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> xfer_done); // R8
  AST_DMA_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> xfer_active); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort && xfer_active |=> !xfer_active && !xfer_done && !stop_req); // R10
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |=> $stable(mode_q)); // R11
  AST_INF_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active && xfer_type == T_INF && !abort |=> xfer_active && !xfer_done); // R9
endmodule

// File: tb/sd_xfer_mode_seq_tb.sv
module sd_xfer_mode_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [1:0] bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic block_done = 1'b0, abort = 1'b0, cap_dma = 1'b0;
  logic [1:0] xfer_type;
  logic xfer_dir, xfer_active, dma_start, stop_req, xfer_done;
  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sd_xfer_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .block_done(block_done), .abort(abort), .cap_dma(cap_dma),
    .xfer_type(xfer_type), .xfer_dir(xfer_dir), .xfer_active(xfer_active),
    .dma_start(dma_start), .stop_req(stop_req), .xfer_done(xfer_done)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(bit blk, bit ab);
    @(negedge clk);
    block_done = blk; abort = ab;
    @(negedge clk);
    block_done = 1'b0; abort = 1'b0;
  endtask

  task automatic launch();
    wr(8'h0E, 2'b10, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(8'h0C, d); chk("R1 mode", d, 0);
    rd(8'h06, d); chk("R1 count", d, 0);
    chk("R1 outputs", {xfer_active, dma_start, stop_req, xfer_done}, 0);
    chk("R4 single at reset", xfer_type, 0);
  endtask

  task automatic t_fields();
    logic [15:0] d;
    wr(8'h0C, 2'b11, 16'hFFFF);
    rd(8'h0C, d); chk("R2 reserved bits read 0", d, 16'h0037);
    chk("R3 dir read", xfer_dir, 1);
    wr(8'h0C, 2'b01, 16'h0000);
    chk("R3 dir write", xfer_dir, 0);
    chk("R4 single", xfer_type, 0);
    wr(8'h0C, 2'b01, 16'h0020);
    chk("R4 infinite", xfer_type, 1);
    wr(8'h0C, 2'b01, 16'h0022);
    chk("R4 stopped", xfer_type, 3);
    wr(8'h06, 2'b11, 16'h0003);
    chk("R4 counted", xfer_type, 2);
  endtask

  task automatic t_single();
    logic [15:0] d;
    wr(8'h0C, 2'b01, 16'h0004);
    wr(8'h06, 2'b11, 16'h0005);
    launch();
    chk("R5 single active", xfer_active, 1);
    pulse(1'b1, 1'b0);
    chk("R12 done", xfer_done, 1);
    chk("R12 no stop", stop_req, 0);
    chk("R12 idle", xfer_active, 0);
    rd(8'h06, d); chk("R12 count kept", d, 5);
  endtask

  task automatic t_counted();
    logic [15:0] d;
    cap_dma = 1'b1;
    wr(8'h0C, 2'b01, 16'h0027);
    wr(8'h06, 2'b11, 16'h0003);
    launch();
    chk("R5 dma start", dma_start, 1);
    chk("R5 active", xfer_active, 1);
    @(negedge clk);
    chk("R5 dma one cycle", dma_start, 0);
    wr(8'h0C, 2'b01, 16'h0000);
    rd(8'h0C, d); chk("R11 mode locked", d, 16'h0027);
    wr(8'h06, 2'b11, 16'h0009);
    rd(8'h06, d); chk("R11 count locked", d, 3);
    launch();
    chk("R11 no relaunch dma", dma_start, 0);
    pulse(1'b1, 1'b0);
    rd(8'h06, d); chk("R6 count 2", d, 2);
    chk("R6 no done", xfer_done, 0);
    pulse(1'b1, 1'b0);
    rd(8'h06, d); chk("R6 count 1", d, 1);
    pulse(1'b1, 1'b0);
    chk("R7 done", xfer_done, 1);
    chk("R8 stop with auto", stop_req, 1);
    chk("R7 idle", xfer_active, 0);
    rd(8'h06, d); chk("R7 count 0", d, 0);
    @(negedge clk);
    chk("R7 done one cycle", {xfer_done, stop_req}, 0);
  endtask

  task automatic t_no_cap();
    cap_dma = 1'b0;
    wr(8'h0C, 2'b01, 16'h0023);
    wr(8'h06, 2'b11, 16'h0002);
    launch();
    chk("R5 no dma without cap", dma_start, 0);
    chk("R5 active no cap", xfer_active, 1);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R7 done no cap", xfer_done, 1);
    chk("R8 no stop when disabled", stop_req, 0);
  endtask

  task automatic t_infinite();
    logic [15:0] d;
    wr(8'h0C, 2'b01, 16'h0025);
    wr(8'h06, 2'b11, 16'h0004);
    launch();
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 1'b0);
      chk("R9 no done", xfer_done, 0);
    end
    chk("R9 still active", xfer_active, 1);
    rd(8'h06, d); chk("R9 count untouched", d, 4);
    pulse(1'b0, 1'b1);
    chk("R10 abort idle", xfer_active, 0);
    chk("R10 abort quiet", {stop_req, xfer_done}, 0);
  endtask

  task automatic t_abort_counted();
    logic [15:0] d;
    wr(8'h0C, 2'b01, 16'h0026);
    wr(8'h06, 2'b11, 16'h0001);
    launch();
    pulse(1'b1, 1'b1);
    chk("R10 abort wins idle", xfer_active, 0);
    chk("R10 abort wins quiet", {stop_req, xfer_done}, 0);
    rd(8'h06, d); chk("R10 no decrement", d, 1);
  endtask

  task automatic t_stopped();
    cap_dma = 1'b1;
    wr(8'h0C, 2'b01, 16'h0023);
    wr(8'h06, 2'b11, 16'h0000);
    chk("R13 type stopped", xfer_type, 3);
    launch();
    chk("R13 no start", xfer_active, 0);
    chk("R13 no dma", dma_start, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_single();
    t_counted();
    t_no_cap();
    t_infinite();
    t_abort_counted();
    t_stopped();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule